// File: doc/BRIEF.md
# Three-Master Parallel Memory Crossbar

This block links three initiators (a processor port, a DMA port and a cipher-engine port) to four memory-like targets: two 4 KiB RAM banks, a 256-byte internal RAM and a 16 KiB register window. Each target has its own round-robin arbiter. Initiators that address different targets are all served in the same clock cycle. Contention for one target is settled so that every waiting initiator is served within a small bounded number of cycles.

Each initiator offers a request on a valid/ready handshake. It drives a byte address, a write flag, 16-bit write data and two byte enables. A transfer happens in a cycle where valid and ready are both high. Ready may stay low because another initiator won the target. While ready is low, the initiator must keep valid high and hold every payload field unchanged. The response comes back one cycle after acceptance. It carries a response-valid strobe, the read data and an error flag. There is no back-pressure on the response path. Each target port is a plain synchronous RAM port: a request in one cycle gives read data in the next.

Top module: `mm_xbar`

## Requirements
- R1: Address decode selects target index 0 for 0x0000–0x0FFF, index 1 for 0x1000–0x1FFF, index 2 for 0x2000–0x20FF and index 3 for 0x4000–0x7FFF. The target sees the word offset (address minus window base) shifted right by one, on its 13-bit slice of `t_addr`.
- R2: A target receives at most one granted request per cycle. When it does, `t_req` is high and `t_addr`, `t_we`, `t_wdata` and `t_be` carry the fields of the granted initiator. `t_req` stays low in any cycle with no grant.
- R3: Initiators whose requests fall in different targets are all accepted in the same cycle.
- R4: On contention the arbiter grants in round-robin order, and the initiator granted last drops to lowest priority. After reset the order is processor (0), DMA (1), cipher (2). A waiting initiator that holds its request is accepted within its third cycle of waiting.
- R5: `m_ready` is high only while the initiator's `m_valid` is high and the transfer is accepted in that cycle. An initiator that drops valid after acceptance sees ready low.
- R6: Every accepted transfer raises `m_rvalid` on that initiator only, one cycle after acceptance. `m_rdata` then holds the addressed word as it was before the access.
- R7: An address outside every window is accepted in the cycle it is presented, with no arbitration. It raises no target request. Its response arrives one cycle later with `m_err` = 1 and `m_rdata` = 0.
- R8: Accesses are 16-bit words, and address bit 0 has no effect. `be` bit 0 enables the low byte and bit 1 the high byte.
- R9: After reset, `m_rvalid`, `m_err`, `m_ready` and `t_req` are all low while no initiator is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 3 | Request valid per initiator (bit 0 processor, 1 DMA, 2 cipher) |
| m_ready | output | 3 | Request accepted this cycle |
| m_addr | input | 48 | Byte address, 16 bits per initiator |
| m_we | input | 3 | Write flag per initiator |
| m_wdata | input | 48 | Write data, 16 bits per initiator |
| m_be | input | 6 | Byte enables, 2 bits per initiator |
| m_rvalid | output | 3 | Response strobe, one cycle after acceptance |
| m_rdata | output | 48 | Response data, 16 bits per initiator |
| m_err | output | 3 | Response error (unmapped address) |
| t_req | output | 4 | Access strobe per target |
| t_addr | output | 52 | Word offset, 13 bits per target |
| t_we | output | 4 | Write flag per target |
| t_wdata | output | 64 | Write data, 16 bits per target |
| t_be | output | 8 | Byte enables, 2 bits per target |
| t_rdata | input | 64 | Registered read data from each target |

## Verification
The bench starts with all three initiators hitting one bank in the same cycle. A fixed-priority arbiter would pass that first round, but it shows up when the same initiator keeps winning over the following rounds. Requests to three different targets in one cycle catch a design that serialises through one shared path, because that design leaves some initiators waiting. Window edges (0x0FFE, 0x1000, 0x20FE, 0x7FFE) and holes (0x2100, 0x3000, 0x8000) catch an off-by-one decode: it would route to the wrong target or miss the error response. Odd-address writes read back through even addresses catch a decoder that lets bit 0 leak into the word offset.

// File: rtl/mm_xbar_pkg.sv
package mm_xbar_pkg;
  localparam int NUM_MST = 3;
  localparam int NUM_TGT = 4;
  localparam int ADDR_W  = 16;
  localparam int TOFF_W  = 13;
  localparam int MST_IDX_W = $clog2(NUM_MST);
  // window base addresses and log2 of window size in bytes, index = target id
  localparam logic [NUM_TGT-1:0][ADDR_W-1:0] WIN_BASE =
    {16'h4000, 16'h2000, 16'h1000, 16'h0000};
  localparam logic [NUM_TGT-1:0][4:0] WIN_LOG2 =
    {5'd14, 5'd8, 5'd12, 5'd12};
endpackage

// File: rtl/mm_xbar_decode.sv
module mm_xbar_decode
  import mm_xbar_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_TGT-1:0] hit,
  output logic               miss,
  output logic [TOFF_W-1:0]  woff
);
  logic [NUM_TGT-1:0][TOFF_W-1:0] off_t;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_win
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] local_byte;
    assign mask       = (ADDR_W'(1) << WIN_LOG2[t]) - ADDR_W'(1);
    assign hit[t]     = (addr & ~mask) == WIN_BASE[t];
    assign local_byte = addr & mask;
    assign off_t[t]   = hit[t] ? local_byte[TOFF_W:1] : '0;
  end

  always_comb begin
    woff = '0;
    for (int t = 0; t < NUM_TGT; t++) woff = woff | off_t[t];
  end

  assign miss = ~|hit;
endmodule

// File: rtl/mm_xbar_rr_arb.sv
module mm_xbar_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    logic found;
    int   idx;
    gnt     = '0;
    win_idx = last_q;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        found      = 1'b1;
        gnt[idx]   = 1'b1;
        win_idx    = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IDX_W'(N - 1);
    else if (|req)    last_q <= win_idx;
  end
endmodule

// File: rtl/mm_xbar_resp.sv
module mm_xbar_resp
  import mm_xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic                      miss,
  input  logic [NUM_TGT-1:0]        hit,
  input  logic [NUM_TGT*DATA_W-1:0] t_rdata,
  output logic                      rvalid,
  output logic                      err,
  output logic [DATA_W-1:0]         rdata
);
  logic [NUM_TGT-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      sel_q  <= '0;
    end else begin
      rvalid <= accept;
      err    <= accept & miss;
      sel_q  <= accept ? hit : '0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int t = 0; t < NUM_TGT; t++)
      if (sel_q[t]) rdata = rdata | t_rdata[t*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/mm_xbar.sv
module mm_xbar
  import mm_xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_MST-1:0]          m_valid,
  output logic [NUM_MST-1:0]          m_ready,
  input  logic [NUM_MST*ADDR_W-1:0]   m_addr,
  input  logic [NUM_MST-1:0]          m_we,
  input  logic [NUM_MST*DATA_W-1:0]   m_wdata,
  input  logic [NUM_MST*(DATA_W/8)-1:0] m_be,
  output logic [NUM_MST-1:0]          m_rvalid,
  output logic [NUM_MST*DATA_W-1:0]   m_rdata,
  output logic [NUM_MST-1:0]          m_err,
  output logic [NUM_TGT-1:0]          t_req,
  output logic [NUM_TGT*TOFF_W-1:0]   t_addr,
  output logic [NUM_TGT-1:0]          t_we,
  output logic [NUM_TGT*DATA_W-1:0]   t_wdata,
  output logic [NUM_TGT*(DATA_W/8)-1:0] t_be,
  input  logic [NUM_TGT*DATA_W-1:0]   t_rdata
);
  localparam int BE_W = DATA_W / 8;

  logic [NUM_MST-1:0][NUM_TGT-1:0] hit_m;
  logic [NUM_MST-1:0]              miss_m;
  logic [NUM_MST-1:0][TOFF_W-1:0]  woff_m;
  logic [NUM_TGT-1:0][NUM_MST-1:0] req_t;
  logic [NUM_TGT-1:0][NUM_MST-1:0] gnt_t;
  logic [NUM_TGT*NUM_MST-1:0]      gnt_flat;
  logic [NUM_MST-1:0]              accept;

  assign gnt_flat = gnt_t;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    mm_xbar_decode dec_i (
      .addr (m_addr[m*ADDR_W +: ADDR_W]),
      .hit  (hit_m[m]),
      .miss (miss_m[m]),
      .woff (woff_m[m])
    );

    always_comb begin
      m_ready[m] = m_valid[m] & miss_m[m];
      for (int t = 0; t < NUM_TGT; t++) m_ready[m] = m_ready[m] | gnt_t[t][m];
    end

    assign accept[m] = m_valid[m] & m_ready[m];

    mm_xbar_resp #(.DATA_W(DATA_W)) resp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept[m]),
      .miss    (miss_m[m]),
      .hit     (hit_m[m]),
      .t_rdata (t_rdata),
      .rvalid  (m_rvalid[m]),
      .err     (m_err[m]),
      .rdata   (m_rdata[m*DATA_W +: DATA_W])
    );
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    for (genvar m = 0; m < NUM_MST; m++) begin : g_req
      assign req_t[t][m] = m_valid[m] & hit_m[m][t];
    end

    mm_xbar_rr_arb #(.N(NUM_MST)) arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_t[t]),
      .gnt   (gnt_t[t])
    );

    always_comb begin
      t_req[t]                     = |gnt_t[t];
      t_addr[t*TOFF_W +: TOFF_W]   = '0;
      t_we[t]                      = 1'b0;
      t_wdata[t*DATA_W +: DATA_W]  = '0;
      t_be[t*BE_W +: BE_W]         = '0;
      for (int m = 0; m < NUM_MST; m++) begin
        if (gnt_t[t][m]) begin
          t_addr[t*TOFF_W +: TOFF_W]  = t_addr[t*TOFF_W +: TOFF_W] | woff_m[m];
          t_we[t]                     = t_we[t] | m_we[m];
          t_wdata[t*DATA_W +: DATA_W] = t_wdata[t*DATA_W +: DATA_W] | m_wdata[m*DATA_W +: DATA_W];
          t_be[t*BE_W +: BE_W]        = t_be[t*BE_W +: BE_W] | m_be[m*BE_W +: BE_W];
        end
      end
    end
  end
endmodule

// File: rtl/mm_xbar_checker.sv
module mm_xbar_checker
  import mm_xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_MST-1:0]        m_valid,
  input logic [NUM_MST-1:0]        m_ready,
  input logic [NUM_MST-1:0]        m_rvalid,
  input logic [NUM_MST-1:0]        m_err,
  input logic [NUM_MST*DATA_W-1:0] m_rdata,
  input logic [NUM_TGT*NUM_MST-1:0] gnt_flat
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_flat[t*NUM_MST +: NUM_MST]));
  end

  for (genvar m = 0; m < NUM_MST; m++) begin : g_m
    logic [1:0] wait_q;
    always_ff @(posedge clk) begin
      if (!rst_n) wait_q <= '0;
      else if (m_valid[m] && !m_ready[m]) wait_q <= (wait_q == 2'd3) ? wait_q : wait_q + 2'd1;
      else wait_q <= '0;
    end

    // R4: bounded wait under contention
    a_r4_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[m] && !m_ready[m]) |-> (wait_q < 2'd2));
    a_r6_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[m] && m_ready[m]) |=> m_rvalid[m]);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_valid[m] && m_ready[m]) |=> !m_rvalid[m]);
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> (m_rvalid[m] && m_rdata[m*DATA_W +: DATA_W] == '0));
    a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready[m] |-> m_valid[m]);
  end
endmodule

bind mm_xbar mm_xbar_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_rvalid (m_rvalid),
  .m_err    (m_err),
  .m_rdata  (m_rdata),
  .gnt_flat (gnt_flat)
);

// File: tb/mm_xbar_tb_top.sv
module mm_xbar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int NT = 4;
  localparam int TW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0]    m_valid = '0;
  logic [NM-1:0]    m_ready;
  logic [NM*16-1:0] m_addr = '0;
  logic [NM-1:0]    m_we = '0;
  logic [NM*16-1:0] m_wdata = '0;
  logic [NM*2-1:0]  m_be = '0;
  logic [NM-1:0]    m_rvalid;
  logic [NM*16-1:0] m_rdata;
  logic [NM-1:0]    m_err;
  logic [NT-1:0]    t_req;
  logic [NT*TW-1:0] t_addr;
  logic [NT-1:0]    t_we;
  logic [NT*16-1:0] t_wdata;
  logic [NT*2-1:0]  t_be;
  logic [NT*16-1:0] t_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_xbar dut_i (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_we(m_we),
    .m_wdata(m_wdata), .m_be(m_be), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .m_err(m_err), .t_req(t_req), .t_addr(t_addr), .t_we(t_we),
    .t_wdata(t_wdata), .t_be(t_be), .t_rdata(t_rdata)
  );

  // target RAM models: synchronous, read-before-write
  logic [15:0] ram [NT][256];
  logic [15:0] rd_q [NT];
  for (genvar t = 0; t < NT; t++) begin : g_ram
    assign t_rdata[t*16 +: 16] = rd_q[t];
    always @(posedge clk) begin
      if (!rst_n) begin
        rd_q[t] <= '0;
        for (int i = 0; i < 256; i++) ram[t][i] <= '0;
      end else if (t_req[t]) begin
        rd_q[t] <= ram[t][t_addr[t*TW +: 8]];
        if (t_we[t]) begin
          if (t_be[t*2])   ram[t][t_addr[t*TW +: 8]][7:0]  <= t_wdata[t*16 +: 8];
          if (t_be[t*2+1]) ram[t][t_addr[t*TW +: 8]][15:8] <= t_wdata[t*16+8 +: 8];
        end
      end
    end
  end

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [15:0] shadow [NT][256];
  logic [NM-1:0] pend = '0;
  logic [15:0] op_addr [NM];
  logic        op_we [NM];
  logic [15:0] op_wdata [NM];
  logic [1:0]  op_be [NM];
  logic        exp_rv [NM];
  logic        exp_er [NM];
  logic [15:0] exp_rd [NM];
  string       exp_tag [NM];
  int          last_gnt [NT];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int tgt_of(input logic [15:0] a);
    if (a < 16'h1000) return 0;
    if (a < 16'h2000) return 1;
    if (a < 16'h2100) return 2;
    if (a >= 16'h4000 && a < 16'h8000) return 3;
    return -1;
  endfunction

  function automatic logic [12:0] woff_of(input logic [15:0] a, input int t);
    case (t)
      0, 1:    return {2'b00, a[11:1]};
      2:       return {6'b0, a[7:1]};
      default: return a[13:1];
    endcase
  endfunction

  task automatic issue(input int m, input logic [15:0] a, input logic we,
                       input logic [15:0] d, input logic [1:0] be);
    pend[m] = 1'b1; op_addr[m] = a; op_we[m] = we; op_wdata[m] = d; op_be[m] = be;
  endtask

  task automatic step();
    int win [NT];
    int tg [NM];
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      chk(m_rvalid[m] === exp_rv[m], "R6", "rvalid", 32'(m_rvalid[m]), 32'(exp_rv[m]));
      if (exp_rv[m]) begin
        chk(m_err[m] === exp_er[m], "R7", "err", 32'(m_err[m]), 32'(exp_er[m]));
        chk(m_rdata[m*16 +: 16] === exp_rd[m], exp_tag[m], "rdata",
            32'(m_rdata[m*16 +: 16]), 32'(exp_rd[m]));
      end
    end
    for (int m = 0; m < NM; m++) begin
      m_valid[m] = pend[m];
      m_addr[m*16 +: 16] = op_addr[m];
      m_we[m] = op_we[m];
      m_wdata[m*16 +: 16] = op_wdata[m];
      m_be[m*2 +: 2] = op_be[m];
    end
    #1;
    for (int m = 0; m < NM; m++) tg[m] = pend[m] ? tgt_of(op_addr[m]) : -2;
    for (int t = 0; t < NT; t++) begin
      win[t] = -1;
      for (int k = 1; k <= NM; k++) begin
        int idx;
        idx = (last_gnt[t] + k) % NM;
        if (win[t] < 0 && pend[idx] && tg[idx] == t) win[t] = idx;
      end
    end
    for (int m = 0; m < NM; m++) begin
      bit exp_acc;
      int rivals;
      string tag;
      exp_acc = pend[m] && (tg[m] == -1 || (tg[m] >= 0 && win[tg[m]] == m));
      rivals = 0;
      for (int o = 0; o < NM; o++) if (o != m && pend[o] && tg[o] == tg[m] && tg[m] >= 0) rivals++;
      tag = !pend[m] ? "R5" : (tg[m] == -1) ? "R7" : (rivals > 0) ? "R4" : "R3";
      chk(m_ready[m] === exp_acc, tag, "ready", 32'(m_ready[m]), 32'(exp_acc));
    end
    for (int t = 0; t < NT; t++) begin
      chk(t_req[t] === (win[t] >= 0), "R2", "t_req", 32'(t_req[t]), 32'(win[t] >= 0));
      if (win[t] >= 0) begin
        int w;
        w = win[t];
        chk(t_addr[t*TW +: TW] === woff_of(op_addr[w], t), "R1", "t_addr",
            32'(t_addr[t*TW +: TW]), 32'(woff_of(op_addr[w], t)));
        chk(t_we[t] === op_we[w] && t_wdata[t*16 +: 16] === op_wdata[w] &&
            t_be[t*2 +: 2] === op_be[w], "R2", "t_fields",
            {t_be[t*2 +: 2], t_we[t], 13'd0, t_wdata[t*16 +: 16]},
            {op_be[w], op_we[w], 13'd0, op_wdata[w]});
      end
    end
    for (int m = 0; m < NM; m++) begin
      if (pend[m] && (tg[m] == -1 || (tg[m] >= 0 && win[tg[m]] == m))) begin
        exp_rv[m] = 1'b1;
        exp_er[m] = (tg[m] == -1);
        if (tg[m] == -1) begin
          exp_rd[m] = '0;
          exp_tag[m] = "R7";
        end else begin
          logic [7:0] ix;
          ix = woff_of(op_addr[m], tg[m]) & 13'hFF;
          exp_rd[m] = shadow[tg[m]][ix];
          exp_tag[m] = op_addr[m][0] ? "R8" : "R6";
          if (op_we[m]) begin
            if (op_be[m][0]) shadow[tg[m]][ix][7:0]  = op_wdata[m][7:0];
            if (op_be[m][1]) shadow[tg[m]][ix][15:8] = op_wdata[m][15:8];
          end
          last_gnt[tg[m]] = m;
        end
        pend[m] = 1'b0;
      end else begin
        exp_rv[m] = 1'b0;
      end
    end
  endtask

  task automatic drain();
    while (|pend) step();
    step();
  endtask

  function automatic logic [15:0] rand_addr();
    logic [15:0] off;
    off = 16'(($urandom % 24) * 2 + ($urandom % 2));
    case ($urandom % 7)
      0: return 16'h0000 + off;
      1: return 16'h1000 + off;
      2: return 16'h2000 + off;
      3: return 16'h4000 + off;
      4: return 16'h7FC0 + off;
      5: return 16'h0FD0 + off;
      default: begin
        case ($urandom % 3)
          0: return 16'h2100 + off;
          1: return 16'h3000 + off;
          default: return 16'h8000 | 16'($urandom % 32768);
        endcase
      end
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog act=%0d exp=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int t = 0; t < NT; t++) begin
      last_gnt[t] = NM - 1;
      for (int i = 0; i < 256; i++) shadow[t][i] = '0;
    end
    for (int m = 0; m < NM; m++) begin
      exp_rv[m] = 1'b0; exp_er[m] = 1'b0; exp_rd[m] = '0; exp_tag[m] = "R6";
      op_addr[m] = '0; op_we[m] = 1'b0; op_wdata[m] = '0; op_be[m] = '0;
    end
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle after reset
    chk(m_rvalid === 3'b000 && m_err === 3'b000, "R9", "resp_idle", {m_rvalid, m_err}, 0);
    chk(m_ready === 3'b000 && t_req === 4'b0000, "R9", "req_idle", {m_ready, t_req}, 0);

    // R4: all three to bank 0 at once; order 0,1,2 after reset
    issue(0, 16'h0010, 1'b1, 16'hA0A0, 2'b11);
    issue(1, 16'h0012, 1'b1, 16'hB1B1, 2'b11);
    issue(2, 16'h0014, 1'b1, 16'hC2C2, 2'b11);
    drain();
    // repeated contention exposes fixed priority
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < NM; m++) issue(m, 16'h0010 + 16'(2*m), 1'b0, 16'h0, 2'b11);
      step();
      issue(0, 16'h0020, 1'b1, 16'(r), 2'b01);
      drain();
    end

    // R3: three different targets in one cycle
    issue(0, 16'h1000, 1'b1, 16'h1111, 2'b11);
    issue(1, 16'h20FE, 1'b1, 16'h2222, 2'b11);
    issue(2, 16'h7FFE, 1'b1, 16'h3333, 2'b11);
    drain();
    // R1: window edges read back
    issue(0, 16'h0FFE, 1'b1, 16'h4444, 2'b11);
    issue(1, 16'h4000, 1'b1, 16'h5555, 2'b11);
    issue(2, 16'h1000, 1'b0, 16'h0, 2'b00);
    drain();
    issue(0, 16'h7FFE, 1'b0, 16'h0, 2'b00);
    issue(1, 16'h20FE, 1'b0, 16'h0, 2'b00);
    issue(2, 16'h0FFE, 1'b0, 16'h0, 2'b00);
    drain();

    // R7: holes and beyond the top window
    issue(0, 16'h2100, 1'b1, 16'hDEAD, 2'b11);
    issue(1, 16'h3FFE, 1'b0, 16'h0, 2'b00);
    issue(2, 16'h8000, 1'b0, 16'h0, 2'b00);
    drain();

    // R8: odd address write, byte lanes, even address read
    issue(0, 16'h1005, 1'b1, 16'h9A7B, 2'b11);
    drain();
    issue(1, 16'h1005, 1'b1, 16'hFF00, 2'b10);
    drain();
    issue(2, 16'h1004, 1'b0, 16'h0, 2'b00);
    drain();

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      for (int m = 0; m < NM; m++)
        if (!pend[m] && ($urandom % 4) != 0)
          issue(m, rand_addr(), 1'(($urandom % 2)), 16'($urandom), 2'($urandom % 4));
      step();
    end
    drain();

    summary();
    $finish;
  end
endmodule